// File: doc/BRIEF.md
# Dual-Clock First-Word-Fall-Through FIFO With Occupancy Flags

This block is a 256-word by 18-bit queue with a write clock and a read clock. The two clocks may be unrelated, or they may be the same net. The writer offers a word by driving a pair of enables, one active-high and one active-low. The word is taken on a write-clock edge only while `in_ready` is high. The reader sees the oldest stored word already sitting in an output register, marked by `out_ready`. It consumes that word by pulling its active-low read strobe and both active-low output enables low together.

Back-pressure works like a valid/ready stream on each side. On the write side, the combined enable is the valid and `in_ready` is the ready; a word offered while `in_ready` is low is dropped and never stored. On the read side, `out_ready` is the valid and the all-low strobe combination is the ready. The output word is held unchanged until it is taken. `data_valid` qualifies the output word and stands in for a tristate output enable.

Pointers cross between the domains as Gray codes. Each domain keeps its own reset synchronizer. The status flags are computed in the write domain. They trail reads by a few write-clock cycles, so they err on the side of "fuller".

Top module: `dcfifo_fwft`

## Requirements
- R1: While `rst_n` is low, `in_ready`, `out_ready` and `half_full` are 0 and `almost` is 1. Reset is asynchronous and must span at least four edges of each clock.
- R2: `in_ready` rises within 6 write-clock cycles after reset is released. A word is stored only on a write-clock edge where `wr_en_hi`=1, `wr_en_lo_n`=0 and `in_ready`=1. The pairs (0,0), (1,1) and (0,1) store nothing.
- R3: The first word written into an empty FIFO reaches `rd_data`, with `out_ready`=1, within 8 read-clock cycles. No read strobe or output enable is needed for this.
- R4: While `out_ready`=1 and any of `rd_en_n`, `oe_a_n`, `oe_b_n` is 1, `out_ready` stays 1 and `rd_data` holds its value.
- R5: Words leave in the order they were written, each exactly once.
- R6: Capacity is 256 words, counting the output register. At 256 stored words `in_ready` is 0. Words offered while it is 0 are discarded and never appear at the output.
- R7: `half_full` is 1 when the stored count is at least 129, and 0 at 128.
- R8: `almost` is 1 when the stored count is 8 or less, or 248 or more. It is 0 at 9 and at 247.
- R9: `data_valid` is 1 exactly when `out_ready`=1 and both `oe_a_n` and `oe_b_n` are 0. It ignores `rd_en_n`.
- R10: After one word is taken from a full FIFO, `in_ready` returns to 1 within 12 write-clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock, free running |
| rd_clk | input | 1 | Read clock, free running, may equal wr_clk |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_data | input | 18 | Word offered for writing |
| wr_en_hi | input | 1 | Write enable, active high |
| wr_en_lo_n | input | 1 | Write enable, active low |
| in_ready | output | 1 | Room available; writes accepted |
| rd_en_n | input | 1 | Read strobe, active low |
| oe_a_n | input | 1 | Output enable A, active low |
| oe_b_n | input | 1 | Output enable B, active low |
| rd_data | output | 18 | Output register holding the oldest word |
| out_ready | output | 1 | Output register holds a valid word |
| data_valid | output | 1 | out_ready qualified by both output enables |
| half_full | output | 1 | Stored count of 129 or more |
| almost | output | 1 | Stored count of 8 or less, or 248 or more |

## Verification
The hardest state to reach is a completely full FIFO, together with the exact flag edges near both ends of the range. Reaching them takes hundreds of accepted writes with the read side held idle. The stimulus fills the queue one word at a time. It pauses at counts 8, 9, 128, 129, 247, 248 and 256, lets the pointer synchronizers settle, and samples the flags. At full it keeps offering words to show they are dropped. It then takes one word to watch `in_ready` recover, and drains everything while checking order. On the way down it re-checks the low `almost` threshold.

// File: rtl/dcfifo_pkg.sv
`timescale 1ns/1ps
package dcfifo_pkg;
  localparam int DEF_DATA_W = 18;
  localparam int DEF_DEPTH  = 256;
  localparam int DEF_AE_LO  = 8;
  localparam int DEF_AF_HI  = 248;

  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/dcfifo_rst_sync.sv
`timescale 1ns/1ps
module dcfifo_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh <= '0;
    else         sh <= {sh[STAGES-2:0], 1'b1};
  end

  assign srst_n = sh[STAGES-1];
endmodule

// File: rtl/dcfifo_gray_sync.sv
`timescale 1ns/1ps
module dcfifo_gray_sync #(
  parameter int W      = 9,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/dcfifo_wr_ctl.sv
`timescale 1ns/1ps
module dcfifo_wr_ctl
  import dcfifo_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int AE_LO = 8,
  parameter int AF_HI = 248,
  parameter int HF_AT = 129,
  parameter int PW    = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_hi,
  input  logic          en_lo_n,
  input  logic [PW-1:0] rq_gray,
  output logic          push,
  output logic [PW-2:0] waddr,
  output logic [PW-1:0] wr_gray,
  output logic          in_ready,
  output logic          half_full,
  output logic          almost
);
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
  localparam logic [PW-1:0] AE_P    = PW'(AE_LO);
  localparam logic [PW-1:0] AF_P    = PW'(AF_HI);
  localparam logic [PW-1:0] HF_P    = PW'(HF_AT);

  logic [PW-1:0] wbin, wbin_nx, rq_bin, cnt_nx;

  assign push    = en_hi & ~en_lo_n & in_ready;
  assign wbin_nx = wbin + PW'(push);
  assign rq_bin  = PW'(gray2bin(32'(rq_gray)));
  assign cnt_nx  = wbin_nx - rq_bin;
  assign waddr   = wbin[PW-2:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin      <= '0;
      wr_gray   <= '0;
      in_ready  <= 1'b0;
      half_full <= 1'b0;
      almost    <= 1'b1;
    end else begin
      wbin      <= wbin_nx;
      wr_gray   <= PW'(bin2gray(32'(wbin_nx)));
      in_ready  <= cnt_nx < DEPTH_P;
      half_full <= cnt_nx >= HF_P;
      almost    <= (cnt_nx <= AE_P) || (cnt_nx >= AF_P);
    end
  end
endmodule

// File: rtl/dcfifo_rd_ctl.sv
`timescale 1ns/1ps
module dcfifo_rd_ctl
  import dcfifo_pkg::*;
#(
  parameter int W  = 18,
  parameter int PW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en_n,
  input  logic          oe_a_n,
  input  logic          oe_b_n,
  input  logic [PW-1:0] wq_gray,
  input  logic [W-1:0]  mem_q,
  output logic [PW-2:0] raddr,
  output logic [PW-1:0] ret_gray,
  output logic [W-1:0]  rd_data,
  output logic          out_ready,
  output logic          data_valid
);
  logic [PW-1:0] fbin, ret_bin, wq_bin, ret_nx;
  logic          consume, fetch;

  assign wq_bin     = PW'(gray2bin(32'(wq_gray)));
  assign consume    = out_ready & ~rd_en_n & ~oe_a_n & ~oe_b_n;
  assign fetch      = (fbin != wq_bin) & (~out_ready | consume);
  assign ret_nx     = ret_bin + PW'(consume);
  assign raddr      = fbin[PW-2:0];
  assign data_valid = out_ready & ~oe_a_n & ~oe_b_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fbin      <= '0;
      ret_bin   <= '0;
      ret_gray  <= '0;
      out_ready <= 1'b0;
      rd_data   <= '0;
    end else begin
      if (fetch) begin
        rd_data <= mem_q;
        fbin    <= fbin + 1'b1;
      end
      out_ready <= fetch | (out_ready & ~consume);
      ret_bin   <= ret_nx;
      ret_gray  <= PW'(bin2gray(32'(ret_nx)));
    end
  end
endmodule

// File: rtl/dcfifo_fwft.sv
`timescale 1ns/1ps
module dcfifo_fwft
  import dcfifo_pkg::*;
#(
  parameter int DATA_W      = DEF_DATA_W,
  parameter int DEPTH       = DEF_DEPTH,
  parameter int AE_LO       = DEF_AE_LO,
  parameter int AF_HI       = DEF_AF_HI,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_en_hi,
  input  logic              wr_en_lo_n,
  output logic              in_ready,
  input  logic              rd_en_n,
  input  logic              oe_a_n,
  input  logic              oe_b_n,
  output logic [DATA_W-1:0] rd_data,
  output logic              out_ready,
  output logic              data_valid,
  output logic              half_full,
  output logic              almost
);
  localparam int PTR_W = $clog2(DEPTH) + 1;
  localparam int HF_AT = DEPTH / 2 + 1;

  logic              wr_srst_n, rd_srst_n, push;
  logic [PTR_W-1:0]  wr_gray, ret_gray, wq_gray, rq_gray;
  logic [PTR_W-2:0]  waddr, raddr;
  logic [DATA_W-1:0] mem_q;
  logic [DATA_W-1:0] mem [DEPTH];

  dcfifo_rst_sync #(.STAGES(SYNC_STAGES)) u_wrst (
    .clk(wr_clk), .arst_n(rst_n), .srst_n(wr_srst_n));
  dcfifo_rst_sync #(.STAGES(SYNC_STAGES)) u_rrst (
    .clk(rd_clk), .arst_n(rst_n), .srst_n(rd_srst_n));

  dcfifo_gray_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rd_clk), .rst_n(rd_srst_n), .d(wr_gray), .q(wq_gray));
  dcfifo_gray_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wr_clk), .rst_n(wr_srst_n), .d(ret_gray), .q(rq_gray));

  dcfifo_wr_ctl #(
    .DEPTH(DEPTH), .AE_LO(AE_LO), .AF_HI(AF_HI), .HF_AT(HF_AT), .PW(PTR_W)
  ) u_wr (
    .clk(wr_clk), .rst_n(wr_srst_n), .en_hi(wr_en_hi), .en_lo_n(wr_en_lo_n),
    .rq_gray(rq_gray), .push(push), .waddr(waddr), .wr_gray(wr_gray),
    .in_ready(in_ready), .half_full(half_full), .almost(almost));

  always_ff @(posedge wr_clk) begin
    if (push) mem[waddr] <= wr_data;
  end
  assign mem_q = mem[raddr];

  dcfifo_rd_ctl #(.W(DATA_W), .PW(PTR_W)) u_rd (
    .clk(rd_clk), .rst_n(rd_srst_n), .rd_en_n(rd_en_n), .oe_a_n(oe_a_n),
    .oe_b_n(oe_b_n), .wq_gray(wq_gray), .mem_q(mem_q), .raddr(raddr),
    .ret_gray(ret_gray), .rd_data(rd_data), .out_ready(out_ready),
    .data_valid(data_valid));
endmodule

// File: rtl/dcfifo_fwft_chk.sv
`timescale 1ns/1ps
module dcfifo_fwft_chk #(
  parameter int W  = 18,
  parameter int PW = 9
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          rd_en_n,
  input logic          oe_a_n,
  input logic          oe_b_n,
  input logic          out_ready,
  input logic [W-1:0]  rd_data,
  input logic          data_valid,
  input logic          half_full,
  input logic          almost,
  input logic [PW-1:0] wr_gray,
  input logic [PW-1:0] ret_gray
);
  AST_OUT_HOLD: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (out_ready && (rd_en_n || oe_a_n || oe_b_n)) |=> (out_ready && $stable(rd_data))); // R4

  AST_RETIRE_IDLE: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !out_ready |=> $stable(ret_gray)); // R5

  AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !in_ready |=> $stable(wr_gray)); // R6

  AST_GRAY_STEP: assert property (@(posedge wr_clk) disable iff (!rst_n)
    $countones(wr_gray ^ $past(wr_gray)) <= 1); // R5

  AST_HF_RISE: assert property (@(posedge wr_clk) disable iff (!rst_n)
    $rose(half_full) |-> !almost); // R7

  AST_VALID_QUAL: assert property (@(posedge rd_clk) disable iff (!rst_n)
    data_valid |-> out_ready); // R9
endmodule

bind dcfifo_fwft dcfifo_fwft_chk #(.W(DATA_W), .PW(PTR_W)) u_chk (.*);

// File: tb/sim_dcfifo_fwft.sv
`timescale 1ns/1ps
module sim_dcfifo_fwft;
  logic        wr_clk = 0, rd_clk = 0, rst_n = 0;
  logic [17:0] wr_data = '0;
  logic        wr_en_hi = 0, wr_en_lo_n = 1, rd_en_n = 1, oe_a_n = 0, oe_b_n = 0;
  logic        in_ready, out_ready, data_valid, half_full, almost;
  logic [17:0] rd_data;
  int nchk = 0, nfail = 0, wseq = 0, rseq = 0;
  bit done = 0;

  always #4   wr_clk = ~wr_clk;
  always #3.5 rd_clk = ~rd_clk;

  dcfifo_fwft u0 (.*);

  function automatic logic [17:0] pat(input int s);
    return 18'(s * 37 + 677) ^ 18'(s << 9);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic settle();
    repeat (12) @(negedge wr_clk);
  endtask

  task automatic push_word();
    @(negedge wr_clk);
    while (!in_ready) @(negedge wr_clk);
    wr_data = pat(wseq); wr_en_hi = 1; wr_en_lo_n = 0;
    @(negedge wr_clk);
    wr_en_hi = 0; wr_en_lo_n = 1; wseq++;
  endtask

  task automatic pop_word(input string req);
    int t = 0;
    @(negedge rd_clk);
    while (!out_ready && t < 20) begin @(negedge rd_clk); t++; end
    check(out_ready, req, "out_ready before pop", out_ready, 1);
    check(rd_data == pat(rseq), req, "popped word", rd_data, pat(rseq));
    oe_a_n = 0; oe_b_n = 0; rd_en_n = 0;
    @(negedge rd_clk);
    rd_en_n = 1; rseq++;
  endtask

  task automatic t_reset();
    rst_n = 0; wr_en_hi = 0; wr_en_lo_n = 1; rd_en_n = 1;
    repeat (6) @(negedge wr_clk);
    repeat (6) @(negedge rd_clk);
    check(!in_ready, "R1", "in_ready in reset", in_ready, 0);
    check(!out_ready, "R1", "out_ready in reset", out_ready, 0);
    check(!half_full, "R1", "half_full in reset", half_full, 0);
    check(almost, "R1", "almost in reset", almost, 1);
    wseq = 0; rseq = 0;
    @(negedge wr_clk); rst_n = 1;
    repeat (6) @(negedge wr_clk);
    check(in_ready, "R2", "in_ready after release", in_ready, 1);
  endtask

  task automatic t_enables();
    logic [1:0] combos [3] = '{2'b00, 2'b11, 2'b01};
    foreach (combos[i]) begin
      @(negedge wr_clk);
      wr_data = 18'h3F0F0; wr_en_hi = combos[i][1]; wr_en_lo_n = combos[i][0];
    end
    @(negedge wr_clk); wr_en_hi = 0; wr_en_lo_n = 1;
    repeat (12) @(negedge rd_clk);
    check(!out_ready, "R2", "out_ready after bad enables", out_ready, 0);
  endtask

  task automatic t_fallthrough();
    int t = 0;
    rd_en_n = 1; oe_a_n = 1; oe_b_n = 1;
    push_word();
    while (!out_ready && t < 8) begin @(negedge rd_clk); t++; end
    check(out_ready, "R3", "fall-through out_ready", out_ready, 1);
    check(rd_data == pat(0), "R3", "fall-through word", rd_data, pat(0));
    check(!data_valid, "R9", "data_valid with oe high", data_valid, 0);
    oe_a_n = 0;
    @(negedge rd_clk);
    check(!data_valid, "R9", "data_valid with oe_b high", data_valid, 0);
    rd_en_n = 0; repeat (4) @(negedge rd_clk);
    check(out_ready && rd_data == pat(0), "R4", "word held, oe_b high", rd_data, pat(0));
    rd_en_n = 1; oe_b_n = 0;
    @(negedge rd_clk);
    check(data_valid, "R9", "data_valid both oe low", data_valid, 1);
    repeat (4) @(negedge rd_clk);
    check(out_ready && rd_data == pat(0), "R4", "word held, rd_en high", rd_data, pat(0));
    pop_word("R5");
    repeat (4) @(negedge rd_clk);
    check(!out_ready, "R5", "empty after single pop", out_ready, 0);
  endtask

  task automatic t_order();
    for (int i = 0; i < 20; i++) push_word();
    for (int i = 0; i < 10; i++) pop_word("R5");
    for (int i = 0; i < 5; i++) push_word();
    while (rseq < wseq) pop_word("R5");
  endtask

  task automatic flag_check(input int cnt);
    settle();
    if (cnt == 8 || cnt == 9 || cnt == 247 || cnt == 248) begin
      bit e = (cnt <= 8 || cnt >= 248);
      check(almost == e, "R8", $sformatf("almost at %0d", cnt), almost, e);
    end
    if (cnt == 128 || cnt == 129) begin
      bit e = (cnt >= 129);
      check(half_full == e, "R7", $sformatf("half_full at %0d", cnt), half_full, e);
    end
  endtask

  task automatic t_fill();
    while (wseq - rseq < 256) begin
      push_word();
      if (wseq - rseq inside {8, 9, 128, 129, 247, 248}) flag_check(wseq - rseq);
    end
    settle();
    check(!in_ready, "R6", "in_ready when full", in_ready, 0);
    @(negedge wr_clk);
    wr_data = 18'h15555; wr_en_hi = 1; wr_en_lo_n = 0;
    repeat (3) @(negedge wr_clk);
    wr_en_hi = 0; wr_en_lo_n = 1;
    pop_word("R5");
    settle();
    check(in_ready, "R10", "in_ready after pop from full", in_ready, 1);
    push_word();
    while (wseq - rseq > 9) pop_word("R5");
    flag_check(9);
    pop_word("R5");
    flag_check(8);
    while (rseq < wseq) pop_word("R5");
    repeat (12) @(negedge rd_clk);
    check(!out_ready, "R6", "no dropped word appears", out_ready, 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_enables();
    t_fallthrough();
    t_order();
    t_reset();
    t_fill();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule